// File: doc/BRIEF.md
# Single-Wire Bus Slave Timing Front-End

This block is the slave-side bit engine for an open-drain, single-wire bus. The master sends every slot and every reset by pulling the line low. The block measures each of these low pulses. A long pulse is taken as a bus reset, which the block answers with a timed presence pulse. A short or medium pulse is a slot. In a write slot the block turns the pulse length into a received bit and strobes it to the command layer above. In a read slot, when the command layer has a zero to return, the block keeps the line low past the master's sample point.

Two timing sets exist, standard and overdrive. The command layer enters overdrive with a one-cycle request. Any reset pulse long enough for standard speed returns the block to standard. While the command layer reports that non-volatile programming is in progress, the block ignores every low pulse on the line. All time limits are counted in ticks, and a prescaler derives the ticks from the clock.

The FSM states and their transitions are these:
- `S_IDLE` waits for the line to go low. It moves to `S_MEAS` for a write slot or a read-one slot. It moves to `S_TXZ` for a read-zero slot. It moves to `S_WAIT_HI` while programming is busy.
- `S_TXZ` drives the line low for the hold time, then moves to `S_MEAS`.
- `S_MEAS` counts the low time. On the rising edge it classifies the pulse and moves to `S_PD_WAIT` after a reset, or to `S_HOLDOFF` otherwise.
- `S_PD_WAIT` waits out the presence delay, then moves to `S_PD_LOW`.
- `S_PD_LOW` drives the presence pulse, then moves to `S_WAIT_HI`.
- `S_WAIT_HI` waits for the line to be high, then moves to `S_HOLDOFF`.
- `S_HOLDOFF` ignores the line for the hold-off time, then moves back to `S_IDLE`.

Top module: `swbus_slave_front`

## Requirements
- R1: In a write slot, a low pulse of 1 to ONE_MAX ticks gives `rx_valid` for one cycle with `rx_bit`=1. The strobe comes in the cycle after the rising edge is sampled. ONE_MAX is 15 at standard speed and 2 at overdrive.
- R2: In a write slot, a low pulse of ZERO_MIN to ZERO_MAX ticks gives `rx_valid` with `rx_bit`=0. These limits are 60 to 120 at standard speed and 6 to 16 at overdrive.
- R3: A pulse shorter than the reset minimum that falls in neither bit window gives a one-cycle `slot_err` and no `rx_valid`.
- R4: A pulse of at least the reset minimum gives a one-cycle `reset_seen` when it ends. The reset minimum is 480 ticks at standard speed and 48 at overdrive. `rx_valid`, `reset_seen` and `slot_err` are never high in the same cycle.
- R5: After `reset_seen`, `drive_low` stays low for PD_WAIT ticks and then stays high for PD_LEN ticks. PD_WAIT/PD_LEN are 30/120 at standard speed and 3/10 at overdrive. No drive lasts longer than a bounded run.
- R6: If `tx_en`=1 and `tx_bit`=0 when the line is first seen low, `drive_low` is high for TX_HOLD ticks from the next cycle. TX_HOLD is 30 at standard speed and 3 at overdrive. The slot raises neither `rx_valid` nor `slot_err`.
- R7: If `tx_en`=1 and `tx_bit`=1, the block does not drive the line and gives no strobe.
- R8: A low pulse that starts within HOLDOFF ticks after a rising edge is ignored. HOLDOFF is 5 at standard speed and 2 at overdrive.
- R9: If `prog_busy` is high when the line goes low, that pulse is ignored, even one of reset length. It gives no strobe and no drive.
- R10: A one-cycle `od_enter` sets `od_mode` to 1, and the overdrive limits then apply. `od_mode` is 0 after reset.
- R11: A reset pulse of at least 480 ticks clears `od_mode`, even in overdrive. An overdrive reset of 48 to 479 ticks leaves `od_mode` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Synchronized line level (0 = low) |
| tx_en | input | 1 | Next slot is a read slot |
| tx_bit | input | 1 | Bit to return in a read slot |
| od_enter | input | 1 | Request to enter overdrive timing |
| prog_busy | input | 1 | Programming in progress; the line is ignored |
| drive_low | output | 1 | Pull the line low |
| rx_valid | output | 1 | Received-bit strobe |
| rx_bit | output | 1 | Received bit value |
| reset_seen | output | 1 | Bus reset detected |
| slot_err | output | 1 | Low pulse outside every window |
| od_mode | output | 1 | 1 = overdrive timing active |

## Verification
Some properties are checked on every cycle:
- The three event strobes are mutually exclusive.
- The presence pulse never starts in the cycle right after `reset_seen`.
- A bit strobe never occurs while the line is driven.
- `od_mode` changes only on a request or together with a reset.
- Every drive run is bounded.

Other behaviour only the bench scenarios can show. This covers the exact window edges (15/16, 59/60, 120/121 ticks), the presence delay and length at both speeds, the read-slot hold time, the hold-off glitch rejection, and the suppression while programming is busy.

// File: rtl/swbus_pkg.sv
package swbus_pkg;
    localparam int LIM_W = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_MEAS, S_TXZ, S_WAIT_HI, S_HOLDOFF, S_PD_WAIT, S_PD_LOW
    } swbus_state_e;

    typedef struct packed {
        logic [LIM_W-1:0] one_max;
        logic [LIM_W-1:0] zero_min;
        logic [LIM_W-1:0] zero_max;
        logic [LIM_W-1:0] rst_min;
        logic [LIM_W-1:0] pd_wait;
        logic [LIM_W-1:0] pd_len;
        logic [LIM_W-1:0] tx_hold;
        logic [LIM_W-1:0] holdoff;
    } swbus_lim_t;
endpackage

// File: rtl/swbus_tick.sv
module swbus_tick #(
    parameter int unsigned DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned LAST = (DIV > 1) ? DIV - 1 : 0;
    localparam int unsigned PW   = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pc_q <= '0;
        else if (pc_q == PW'(LAST)) pc_q <= '0;
        else                        pc_q <= pc_q + 1'b1;
    end

    assign tick = (pc_q == PW'(LAST));
endmodule

// File: rtl/swbus_limits.sv
module swbus_limits
    import swbus_pkg::*;
#(
    parameter int unsigned STD_ONE_MAX  = 15,
    parameter int unsigned STD_ZERO_MIN = 60,
    parameter int unsigned STD_ZERO_MAX = 120,
    parameter int unsigned STD_RST_MIN  = 480,
    parameter int unsigned STD_PD_WAIT  = 30,
    parameter int unsigned STD_PD_LEN   = 120,
    parameter int unsigned STD_TX_HOLD  = 30,
    parameter int unsigned STD_HOLDOFF  = 5,
    parameter int unsigned OD_ONE_MAX   = 2,
    parameter int unsigned OD_ZERO_MIN  = 6,
    parameter int unsigned OD_ZERO_MAX  = 16,
    parameter int unsigned OD_RST_MIN   = 48,
    parameter int unsigned OD_PD_WAIT   = 3,
    parameter int unsigned OD_PD_LEN    = 10,
    parameter int unsigned OD_TX_HOLD   = 3,
    parameter int unsigned OD_HOLDOFF   = 2
) (
    input  logic       od,
    output swbus_lim_t lim
);
    swbus_lim_t std_set, od_set;

    assign std_set = '{LIM_W'(STD_ONE_MAX), LIM_W'(STD_ZERO_MIN), LIM_W'(STD_ZERO_MAX),
                       LIM_W'(STD_RST_MIN), LIM_W'(STD_PD_WAIT), LIM_W'(STD_PD_LEN),
                       LIM_W'(STD_TX_HOLD), LIM_W'(STD_HOLDOFF)};
    assign od_set  = '{LIM_W'(OD_ONE_MAX), LIM_W'(OD_ZERO_MIN), LIM_W'(OD_ZERO_MAX),
                       LIM_W'(OD_RST_MIN), LIM_W'(OD_PD_WAIT), LIM_W'(OD_PD_LEN),
                       LIM_W'(OD_TX_HOLD), LIM_W'(OD_HOLDOFF)};

    assign lim = od ? od_set : std_set;
endmodule

// File: rtl/swbus_slave_front.sv
module swbus_slave_front
    import swbus_pkg::*;
#(
    parameter int unsigned CYC_PER_TICK = 250,
    parameter int unsigned STD_RST_MIN  = 480,
    parameter int unsigned OD_RST_MIN   = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    input  logic tx_en,
    input  logic tx_bit,
    input  logic od_enter,
    input  logic prog_busy,
    output logic drive_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic reset_seen,
    output logic slot_err,
    output logic od_mode
);
    localparam logic [LIM_W-1:0] STD_RST = LIM_W'(STD_RST_MIN);
    localparam logic [LIM_W-1:0] ONE     = LIM_W'(1);

    swbus_state_e     st_q, st_d;
    logic [LIM_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             rd_q, rd_d, od_q, od_d;
    logic             rxv_d, rxb_d, rxb_q, rxv_q, rst_d, rst_q, err_d, err_q;
    logic             tick;
    swbus_lim_t       lim;

    swbus_tick #(.DIV(CYC_PER_TICK)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    swbus_limits #(.STD_RST_MIN(STD_RST_MIN), .OD_RST_MIN(OD_RST_MIN)) u_lim (
        .od(od_q), .lim(lim));

    assign cnt_inc = (tick && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        rd_d  = rd_q;
        od_d  = od_q | od_enter;
        rxv_d = 1'b0;
        rxb_d = rxb_q;
        rst_d = 1'b0;
        err_d = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (!bus_in) begin
                    if (prog_busy) begin
                        st_d = S_WAIT_HI;
                    end else begin
                        cnt_d = ONE;
                        rd_d  = tx_en;
                        st_d  = (tx_en && !tx_bit) ? S_TXZ : S_MEAS;
                    end
                end
            end
            S_TXZ: begin
                cnt_d = cnt_inc;
                if (cnt_q >= lim.tx_hold) st_d = S_MEAS;
            end
            S_MEAS: begin
                if (!bus_in) begin
                    cnt_d = cnt_inc;
                end else begin
                    st_d  = S_HOLDOFF;
                    cnt_d = ONE;
                    if (cnt_q >= STD_RST) begin
                        rst_d = 1'b1;
                        od_d  = 1'b0;
                        st_d  = S_PD_WAIT;
                    end else if (cnt_q >= lim.rst_min) begin
                        rst_d = 1'b1;
                        st_d  = S_PD_WAIT;
                    end else if (rd_q) begin
                        rxv_d = 1'b0;
                    end else if (cnt_q <= lim.one_max) begin
                        rxv_d = 1'b1;
                        rxb_d = 1'b1;
                    end else if (cnt_q >= lim.zero_min && cnt_q <= lim.zero_max) begin
                        rxv_d = 1'b1;
                        rxb_d = 1'b0;
                    end else begin
                        err_d = 1'b1;
                    end
                end
            end
            S_WAIT_HI: begin
                if (bus_in) begin
                    st_d  = S_HOLDOFF;
                    cnt_d = ONE;
                end
            end
            S_HOLDOFF: begin
                if (cnt_q >= lim.holdoff) st_d = S_IDLE;
                else                      cnt_d = cnt_inc;
            end
            S_PD_WAIT: begin
                if (cnt_q >= lim.pd_wait) begin
                    st_d  = S_PD_LOW;
                    cnt_d = ONE;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            S_PD_LOW: begin
                if (cnt_q >= lim.pd_len) st_d = S_WAIT_HI;
                else                     cnt_d = cnt_inc;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            rd_q  <= 1'b0;
            od_q  <= 1'b0;
            rxv_q <= 1'b0;
            rxb_q <= 1'b0;
            rst_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rd_q  <= rd_d;
            od_q  <= od_d;
            rxv_q <= rxv_d;
            rxb_q <= rxb_d;
            rst_q <= rst_d;
            err_q <= err_d;
        end
    end

    always_comb begin
        drive_low  = (st_q == S_TXZ) || (st_q == S_PD_LOW);
        rx_valid   = rxv_q;
        rx_bit     = rxb_q;
        reset_seen = rst_q;
        slot_err   = err_q;
        od_mode    = od_q;
    end
endmodule

// File: rtl/swbus_slave_front_chk.sv
module swbus_slave_front_chk #(
    parameter int unsigned DRV_MAX = 256
) (
    input logic clk,
    input logic rst_n,
    input logic drive_low,
    input logic rx_valid,
    input logic reset_seen,
    input logic slot_err,
    input logic od_mode,
    input logic od_enter
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_q <= '0;
        else if (!drive_low) run_q <= '0;
        else if (run_q != '1) run_q <= run_q + 1'b1;
    end

    p_events_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, reset_seen, slot_err}));

    p_presence_delayed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !drive_low);

    p_drive_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 16'(DRV_MAX));

    p_no_bit_while_driving_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !drive_low);

    p_od_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_mode) |-> $past(od_enter));

    p_od_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_mode) |-> reset_seen);
endmodule

bind swbus_slave_front swbus_slave_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .drive_low(drive_low), .rx_valid(rx_valid),
    .reset_seen(reset_seen), .slot_err(slot_err), .od_mode(od_mode), .od_enter(od_enter));

// File: tb/swbus_slave_front_test.sv
module swbus_slave_front_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_low = 1'b0;
    logic tx_en = 1'b0, tx_bit = 1'b0, od_enter = 1'b0, prog_busy = 1'b0;
    logic bus_in, drive_low, rx_valid, rx_bit, reset_seen, slot_err, od_mode;

    int checks = 0, errors = 0, cyc = 0;
    int rst_cnt, err_cnt, drv_cnt, drv_first, rst_cyc;
    int rx_q[$];
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign bus_in = !(master_low || drive_low);

    swbus_slave_front #(.CYC_PER_TICK(1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .tx_en(tx_en), .tx_bit(tx_bit),
        .od_enter(od_enter), .prog_busy(prog_busy), .drive_low(drive_low),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .reset_seen(reset_seen),
        .slot_err(slot_err), .od_mode(od_mode));

    // behavioural observer: records events seen on the ports each cycle
    always @(negedge clk) begin
        if (rx_valid) rx_q.push_back(int'(rx_bit));
        if (reset_seen) begin rst_cnt++; rst_cyc = cyc; end
        if (slot_err) err_cnt++;
        if (drive_low) begin
            drv_cnt++;
            if (drv_first < 0) drv_first = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear();
        rx_q.delete();
        rst_cnt = 0; err_cnt = 0; drv_cnt = 0; drv_first = -1; rst_cyc = -1;
    endtask

    task automatic pulse(input int len, input int gap);
        @(negedge clk);
        master_low = 1'b1;
        repeat (len) @(negedge clk);
        master_low = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic write_slot(input string req, input int len, input int exp_bit, input int exp_err);
        clear();
        pulse(len, 20);
        chk({req, " strobes"}, rx_q.size(), (exp_bit < 0) ? 0 : 1);
        if (exp_bit >= 0 && rx_q.size() == 1) chk({req, " bit"}, rx_q[0], exp_bit);
        chk({req, " err"}, err_cnt, exp_err);
    endtask

    task automatic reset_pulse(input string req, input int len, input int pdw, input int pdl);
        clear();
        pulse(len, pdw + pdl + 30);
        chk({req, " reset_seen"}, rst_cnt, 1);
        chk({req, " presence delay"}, drv_first - rst_cyc, pdw);
        chk({req, " presence length"}, drv_cnt, pdl);
        chk({req, " no bit"}, rx_q.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear();
        repeat (5) @(negedge clk);
        chk("R10 reset od_mode", int'(od_mode), 0);
        chk("R5 reset drive_low", int'(drive_low), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        write_slot("R1 std one 6", 6, 1, 0);
        write_slot("R1 std one edge 15", 15, 1, 0);
        write_slot("R3 std gap 16", 16, -1, 1);
        write_slot("R3 std gap 59", 59, -1, 1);
        write_slot("R2 std zero 60", 60, 0, 0);
        write_slot("R2 std zero 80", 80, 0, 0);
        write_slot("R2 std zero edge 120", 120, 0, 0);
        write_slot("R3 std gap 121", 121, -1, 1);
        write_slot("R3 std long 400", 400, -1, 1);
        reset_pulse("R4 R5 std reset", 500, 30, 120);

        // read slot returning zero
        clear();
        tx_en = 1'b1; tx_bit = 1'b0;
        pulse(2, 60);
        chk("R6 read zero hold", drv_cnt, 30);
        chk("R6 read zero no bit", rx_q.size(), 0);
        chk("R6 read zero no err", err_cnt, 0);
        // read slot returning one
        clear();
        tx_bit = 1'b1;
        pulse(2, 30);
        chk("R7 read one no drive", drv_cnt, 0);
        chk("R7 read one no bit", rx_q.size() + err_cnt, 0);
        tx_en = 1'b0;

        // glitch inside hold-off
        clear();
        @(negedge clk); master_low = 1'b1;
        repeat (6) @(negedge clk); master_low = 1'b0;
        @(negedge clk); master_low = 1'b1;
        repeat (2) @(negedge clk); master_low = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 holdoff strobes", rx_q.size(), 1);
        chk("R8 holdoff errors", err_cnt, 0);

        // programming busy
        clear();
        prog_busy = 1'b1;
        pulse(80, 20);
        pulse(500, 200);
        chk("R9 busy no bit", rx_q.size(), 0);
        chk("R9 busy no reset", rst_cnt, 0);
        chk("R9 busy no drive", drv_cnt, 0);
        chk("R9 busy no err", err_cnt, 0);
        prog_busy = 1'b0;
        repeat (10) @(negedge clk);
        write_slot("R9 after busy one", 6, 1, 0);

        // overdrive
        @(negedge clk); od_enter = 1'b1;
        @(negedge clk); od_enter = 1'b0;
        chk("R10 od set", int'(od_mode), 1);
        write_slot("R10 od one 2", 2, 1, 0);
        write_slot("R10 od zero 8", 8, 0, 0);
        write_slot("R10 od gap 4", 4, -1, 1);
        clear();
        tx_en = 1'b1; tx_bit = 1'b0;
        pulse(1, 20);
        tx_en = 1'b0;
        chk("R10 od read zero hold", drv_cnt, 3);
        reset_pulse("R11 od reset", 60, 3, 10);
        chk("R11 od kept", int'(od_mode), 1);
        reset_pulse("R11 std reset in od", 500, 30, 120);
        chk("R11 od cleared", int'(od_mode), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule